// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This unit holds the standard event group of an instrument status system and builds the status byte from it. Instrument events arrive as one-cycle set pulses and are latched into an 8-bit event register. A separate power-up pulse always sets the power-on flag. The event register is masked by an event enable register, and the OR of the result becomes the event summary bit. The status byte also gathers summary bits from the other groups: the operation and questionable group summaries, message-available, and three auxiliary summary inputs.

The status byte is masked by a service request enable register. The masked result gives the master summary status (MSS). A rising MSS latches a request-service flag, which drives the service request line `srq`. The host reaches the unit through a command port. `cmd_valid` is sampled on every clock. There is no back-pressure: a command is taken in the cycle it is offered. The port has six operations: status byte read, serial poll, event read-and-clear, enable register writes, and the power-on-clear flag write. A read returns its data on `rsp_data` with a one-cycle `rsp_valid` pulse in the cycle after the command. Writes produce no response.

The enable registers and the power-on-clear flag live in a retained bank. A warm reset (`rst_n`) leaves that bank unchanged. The `pwr_up` input models a power cycle, and at that point the power-on-clear rule is applied.

Top module: `svc_req_status`

## Requirements
- R1: While `rst_n` is low and after it, `srq` and `rsp_valid` are 0, and an event read (op 3) returns 0x00.
- R2: An event set pulse on bit i latches bit i of the event register. Op 3 returns the register and clears it. A set pulse that arrives in the same cycle as op 3 is kept for the next read.
- R3: A `pwr_up` pulse sets event bit 7, the power-on flag.
- R4: Status byte bit 5 is the OR of the event register ANDed with the event enable register. The event enable is written by op 4.
- R5: Status byte bits 2..0 are `aux_sum`, bit 3 is `ques_sum`, bit 4 is `mav`, and bit 7 is `oper_sum`.
- R6: Op 1 returns the status byte with MSS in bit 6 and leaves `srq` unchanged.
- R7: MSS (also output `mss`) is the OR of status byte bits 0..5 and 7, each ANDed with its service request enable bit. The service request enable is written by op 5, and its bit 6 is ignored.
- R8: `srq` rises in the cycle after MSS rises. It stays high until a serial poll, even if MSS falls.
- R9: Op 2 (serial poll) returns the status byte with the request flag in bit 6 and clears `srq` in the next cycle. A new MSS rise in the same cycle as the poll wins.
- R10: When the power-on-clear flag (op 6, data bit 0, initially 1) is 1, `pwr_up` clears the event enable. When the flag is 0, `pwr_up` keeps the event enable.
- R11: A warm reset keeps the event enable and service request enable values.
- R12: Ops 1, 2 and 3 give `rsp_valid` high for exactly the next cycle. Ops 0, 4, 5 and 6 give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, active low; retained bank not affected |
| pwr_up | input | 1 | One-cycle power-up pulse |
| evt_set | input | 8 | Event set pulses, one per event bit |
| ques_sum | input | 1 | Questionable group summary |
| oper_sum | input | 1 | Operation group summary |
| mav | input | 1 | Message available |
| aux_sum | input | 3 | Other summary bits for status byte bits 2..0 |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 3 | 0 nop, 1 status read, 2 serial poll, 3 event read-clear, 4 write event enable, 5 write request enable, 6 write power-on-clear |
| cmd_data | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Read data |
| mss | output | 1 | Master summary status |
| srq | output | 1 | Service request |

## Verification
A flag or enable bit that is wrong inside the unit shows up within a cycle, either in the status byte read or in the event read. The request-service flag is the one piece of state that only shows up over time. If it is not held after MSS falls, `srq` drops with no poll. If the poll fails to clear it, `srq` stays high one cycle after the poll. A lost power-on-clear rule shows at the next `pwr_up`: the power-on event either raises a request or fails to raise one.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int STB_W    = 8;
  localparam int AUX_W    = 3;
  localparam int QUES_BIT = 3;
  localparam int MAV_BIT  = 4;
  localparam int ESB_BIT  = 5;
  localparam int MSS_BIT  = 6;
  localparam int OPER_BIT = 7;
  localparam int PON_BIT  = 7;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_RD_STB = 3'd1,
    OP_POLL   = 3'd2,
    OP_RD_ESR = 3'd3,
    OP_WR_ESE = 3'd4,
    OP_WR_SRE = 3'd5,
    OP_WR_PSC = 3'd6
  } host_op_e;
endpackage

// File: rtl/std_event_grp.sv
module std_event_grp
  import srq_pkg::*;
#(
  parameter int W = STB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_up,
  input  logic [W-1:0] evt_set,
  input  logic         rd_clr,
  input  logic         ese_we,
  input  logic         psc_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] esr,
  output logic         esb
);
  logic [W-1:0] esr_q;
  logic [W-1:0] pon_vec;
  // retained bank: initial value only, untouched by warm reset
  logic [W-1:0] ese_q = '0;
  logic         psc_q = 1'b1;

  always_comb begin
    pon_vec          = '0;
    pon_vec[PON_BIT] = pwr_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) esr_q <= '0;
    else        esr_q <= (rd_clr ? '0 : esr_q) | evt_set | pon_vec;
  end

  always_ff @(posedge clk) begin
    if (pwr_up && psc_q) ese_q <= '0;
    else if (ese_we)     ese_q <= wdata;
    if (psc_we)          psc_q <= wdata[0];
  end

  assign esr = esr_q;
  assign esb = |(esr_q & ese_q);
endmodule

// File: rtl/stb_summary.sv
module stb_summary
  import srq_pkg::*;
#(
  parameter int W = STB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stb_raw,
  input  logic         sre_we,
  input  logic [W-1:0] wdata,
  input  logic         poll,
  output logic         mss,
  output logic         rqs
);
  localparam logic [W-1:0] SRE_MASK = ~(W'(1) << MSS_BIT);

  logic [W-1:0] sre_q = '0;
  logic         mss_prev;
  logic         rqs_q;
  logic         mss_c;

  assign mss_c = |(stb_raw & sre_q & SRE_MASK);

  always_ff @(posedge clk) begin
    if (sre_we) sre_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mss_prev <= 1'b0;
      rqs_q    <= 1'b0;
    end else begin
      mss_prev <= mss_c;
      rqs_q    <= (rqs_q & ~poll) | (mss_c & ~mss_prev);
    end
  end

  assign mss = mss_c;
  assign rqs = rqs_q;
endmodule

// File: rtl/svc_req_status.sv
module svc_req_status
  import srq_pkg::*;
#(
  parameter int W  = STB_W,
  parameter int AW = AUX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_up,
  input  logic [W-1:0]  evt_set,
  input  logic          ques_sum,
  input  logic          oper_sum,
  input  logic          mav,
  input  logic [AW-1:0] aux_sum,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_data,
  output logic          mss,
  output logic          srq
);
  logic         is_rd_stb, is_poll, is_rd_esr;
  logic [W-1:0] esr;
  logic         esb;
  logic [W-1:0] stb_raw;
  logic         mss_w, rqs_w;
  logic         rv_q;
  logic [W-1:0] rd_q;

  assign is_rd_stb = cmd_valid && (cmd_op == OP_RD_STB);
  assign is_poll   = cmd_valid && (cmd_op == OP_POLL);
  assign is_rd_esr = cmd_valid && (cmd_op == OP_RD_ESR);

  std_event_grp #(.W(W)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_up (pwr_up),
    .evt_set(evt_set),
    .rd_clr (is_rd_esr),
    .ese_we (cmd_valid && (cmd_op == OP_WR_ESE)),
    .psc_we (cmd_valid && (cmd_op == OP_WR_PSC)),
    .wdata  (cmd_data),
    .esr    (esr),
    .esb    (esb)
  );

  always_comb begin
    stb_raw           = '0;
    stb_raw[AW-1:0]   = aux_sum;
    stb_raw[QUES_BIT] = ques_sum;
    stb_raw[MAV_BIT]  = mav;
    stb_raw[ESB_BIT]  = esb;
    stb_raw[OPER_BIT] = oper_sum;
  end

  stb_summary #(.W(W)) u_sum (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_raw(stb_raw),
    .sre_we (cmd_valid && (cmd_op == OP_WR_SRE)),
    .wdata  (cmd_data),
    .poll   (is_poll),
    .mss    (mss_w),
    .rqs    (rqs_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else begin
      rv_q <= is_rd_stb | is_poll | is_rd_esr;
      rd_q <= '0;
      if (is_rd_esr) rd_q <= esr;
      else if (is_rd_stb || is_poll) begin
        rd_q          <= stb_raw;
        rd_q[MSS_BIT] <= is_poll ? rqs_w : mss_w;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign mss       = mss_w;
  assign srq       = rqs_w;
endmodule

// File: rtl/svc_req_status_chk.sv
module svc_req_status_chk
  import srq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic       mss,
  input logic       srq
);
  // R8
  srq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srq && !(cmd_valid && cmd_op == OP_POLL)) |=> srq);

  // R8
  srq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mss) |=> srq);

  // R9
  poll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POLL && !$rose(mss)) |=> !srq);

  // R9
  poll_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_POLL) |=> (rsp_data[6] == $past(srq)));

  // R6
  stb_bit6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD_STB) |=> (rsp_data[6] == $past(mss)));

  // R12
  rsp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_RD_STB || cmd_op == OP_POLL || cmd_op == OP_RD_ESR))
    |=> rsp_valid);

  // R12
  rsp_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (cmd_op == OP_RD_STB || cmd_op == OP_POLL || cmd_op == OP_RD_ESR))
    |=> !rsp_valid);
endmodule

bind svc_req_status svc_req_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .mss      (mss),
  .srq      (srq)
);

// File: tb/svc_req_status_tb.sv
module svc_req_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_up = 1'b0;
  logic [7:0] evt_set = '0;
  logic       ques_sum = 1'b0, oper_sum = 1'b0, mav = 1'b0;
  logic [2:0] aux_sum = '0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       mss, srq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  svc_req_status u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .evt_set(evt_set),
    .ques_sum(ques_sum), .oper_sum(oper_sum), .mav(mav), .aux_sum(aux_sum),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mss(mss), .srq(srq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] d,
                       output logic rv, output logic [7:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    rv = rsp_valid; rd = rsp_data;
  endtask

  task automatic rd_op(input logic [2:0] op, input string req, input logic [7:0] exp);
    logic rv; logic [7:0] rd;
    do_op(op, 8'h00, rv, rd);
    chk({req, " rsp_valid"}, {7'd0, rv}, 8'h01);
    chk(req, rd, exp);
  endtask

  task automatic wr_op(input logic [2:0] op, input logic [7:0] d);
    logic rv; logic [7:0] rd;
    do_op(op, d, rv, rd);
    chk("R12 no response on write", {7'd0, rv}, 8'h00);
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk); evt_set = v;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic pulse_pwr();
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 srq in reset", {7'd0, srq}, 8'h00);
    chk("R1 rsp_valid in reset", {7'd0, rsp_valid}, 8'h00);
    rst_n = 1'b1;
    settle();
    chk("R1 srq after reset", {7'd0, srq}, 8'h00);
    rd_op(3'd3, "R1 event reg after reset", 8'h00);
  endtask

  task automatic t_events();
    logic rv; logic [7:0] rd;
    pulse_evt(8'h05);
    pulse_evt(8'h02);
    rd_op(3'd3, "R2 latched events", 8'h07);
    rd_op(3'd3, "R2 cleared by read", 8'h00);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd3; evt_set = 8'h10;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; evt_set = '0;
    rv = rsp_valid; rd = rsp_data;
    chk("R2 read with same-cycle set", rd, 8'h00);
    rd_op(3'd3, "R2 same-cycle set kept", 8'h10);
    do_op(3'd0, 8'h00, rv, rd);
    chk("R12 no response on nop", {7'd0, rv}, 8'h00);
  endtask

  task automatic t_map();
    ques_sum = 1'b1; oper_sum = 1'b1; mav = 1'b0; aux_sum = 3'b101;
    rd_op(3'd1, "R5 status byte map", 8'h8D);
    ques_sum = 1'b0; oper_sum = 1'b0; mav = 1'b1; aux_sum = 3'b010;
    rd_op(3'd1, "R5 status byte map mav", 8'h12);
    mav = 1'b0; aux_sum = '0;
  endtask

  task automatic t_mask();
    logic rv; logic [7:0] rd;
    ques_sum = 1'b1; oper_sum = 1'b1; mav = 1'b1; aux_sum = 3'b111;
    wr_op(3'd5, 8'h40);
    settle();
    chk("R7 enable bit 6 ignored mss", {7'd0, mss}, 8'h00);
    chk("R7 enable bit 6 ignored srq", {7'd0, srq}, 8'h00);
    oper_sum = 1'b0; mav = 1'b0; aux_sum = '0;
    wr_op(3'd5, 8'h08);
    settle();
    chk("R7 mss from bit 3", {7'd0, mss}, 8'h01);
    chk("R8 srq after mss rise", {7'd0, srq}, 8'h01);
    ques_sum = 1'b0;
    settle();
    chk("R8 srq held after mss falls", {7'd0, srq}, 8'h01);
    rd_op(3'd1, "R6 status read mss low", 8'h00);
    chk("R6 status read keeps srq", {7'd0, srq}, 8'h01);
    do_op(3'd2, 8'h00, rv, rd);
    chk("R9 poll returns flag", rd, 8'h40);
    chk("R9 poll clears srq", {7'd0, srq}, 8'h00);
    wr_op(3'd5, 8'h00);
  endtask

  task automatic t_pwrup();
    logic rv; logic [7:0] rd;
    wr_op(3'd4, 8'h80);
    pulse_pwr();
    rd_op(3'd1, "R10 clear on power-up", 8'h00);
    rd_op(3'd3, "R3 power-on flag", 8'h80);
    wr_op(3'd6, 8'h00);
    wr_op(3'd4, 8'h80);
    wr_op(3'd5, 8'h20);
    pulse_pwr();
    settle();
    chk("R10 kept enable gives srq", {7'd0, srq}, 8'h01);
    rd_op(3'd1, "R4 R6 event summary and mss", 8'h60);
    chk("R6 srq unchanged by status read", {7'd0, srq}, 8'h01);
    do_op(3'd2, 8'h00, rv, rd);
    chk("R9 poll byte", rd, 8'h60);
    chk("R9 srq cleared", {7'd0, srq}, 8'h00);
    settle();
    chk("R8 no new rise keeps srq low", {7'd0, srq}, 8'h00);
    rd_op(3'd3, "R3 flag read and cleared", 8'h80);
  endtask

  task automatic t_warm();
    logic rv; logic [7:0] rd;
    wr_op(3'd4, 8'h01);
    wr_op(3'd5, 8'h20);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    settle();
    chk("R1 srq after warm reset", {7'd0, srq}, 8'h00);
    pulse_evt(8'h01);
    settle();
    chk("R11 enables retained", {7'd0, srq}, 8'h01);
    rd_op(3'd1, "R4 summary via bit 0 enable", 8'h60);
    do_op(3'd2, 8'h00, rv, rd);
    chk("R9 poll after warm reset", rd, 8'h60);
  endtask

  initial begin
    t_reset();
    t_events();
    t_map();
    t_mask();
    t_pwrup();
    t_warm();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule